// File: doc/BRIEF.md
# Set-Associative Way Predictor

This block steers read data out of a two-way set-associative cache before the tag comparison for the access is known. Every set keeps one bit that names the way expected to hold the data. When a request arrives, the data array is read at the predicted way straight away. A correct guess therefore needs no way-select multiplexer after the tag compare, and the data is ready one cycle after the request.

The tag comparison runs outside the block and arrives with the request as one hit flag per way. If only the other way hits, the block marks the guess as wrong and flips that set's prediction bit. It then spends one more cycle reading the correct way and returns that data with a mispredict flag. If neither way hits, the block reports a miss and keeps the prediction.

The data array is a plain synchronous memory that is written through a separate fill port. Choosing a victim way on a miss is left to the surrounding cache.

Top module: `way_predictor`

## Requirements
- R1: After reset every set predicts way 0, `rsp_valid` is low and `req_ready` is high.
- R2: When the predicted way's hit flag is set, `rsp_valid` rises in the cycle after the request is accepted. `rsp_data` then carries that way's word for the requested set, and `rsp_mispredict` and `rsp_miss` are both low.
- R3: When only the non-predicted way hits, no response appears in the next cycle and `req_ready` is low in that cycle. The response comes one cycle later with the other way's word and `rsp_mispredict` high.
- R4: A mispredicted hit flips the prediction bit of that set, so a repeat of the same access is predicted correctly.
- R5: When neither hit flag is set, the response arrives one cycle after acceptance with `rsp_miss` high and `rsp_mispredict` low, and the set's prediction bit is unchanged.
- R6: Each set has its own prediction bit. An update to one set leaves every other set's prediction unchanged.
- R7: When both hit flags are set, the access is treated as a correct prediction and returns the predicted way's word.
- R8: A request presented while `req_ready` is low is ignored. It produces no response and changes no prediction bit.
- R9: A fill writes `fill_data` into the word at way `fill_way` (0 or 1) and set `fill_idx`, and later reads return that word. A fill does not change any prediction bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_idx | input | SET_BITS | Set index of the lookup |
| req_hit | input | 2 | Tag compare result, bit n set when way n hits |
| fill_en | input | 1 | Write one data word |
| fill_way | input | 1 | Way written by the fill |
| fill_idx | input | SET_BITS | Set written by the fill |
| fill_data | input | DATA_W | Word written by the fill |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | DATA_W | Word read for the response |
| rsp_mispredict | output | 1 | Data came from the non-predicted way after a correction cycle |
| rsp_miss | output | 1 | Neither way hit |

## Verification
The bench uses the default parameters: 64 sets (SET_BITS = 6) and 32-bit data words. With 64 sets the bench can visit every set and see each prediction bit at its reset value. The set indices 0 and 63 sit at the edges of the index range, and their bits are flipped to show that neighbouring sets keep their own state. Each way of each set gets a distinct word from the fill port, so data read from the wrong way or the wrong set shows up at once. A request driven during the correction cycle checks that a stalled request is ignored.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic {
    ST_LOOKUP,
    ST_CORRECT
  } wp_state_e;

  localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int unsigned SET_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_BITS-1:0] rd_idx,
  output logic                rd_way,
  input  logic                upd_en,
  input  logic [SET_BITS-1:0] upd_idx,
  input  logic                upd_way
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0] guess_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      guess_q <= '0;
    end else if (upd_en) begin
      guess_q[upd_idx] <= upd_way;
    end
  end

  assign rd_way = guess_q[rd_idx];

  // An update always replaces the stored guess with the opposite way.
  AST_UPDATE_FLIPS: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (upd_way != guess_q[upd_idx])); // R4
endmodule

// File: rtl/wp_data_ram.sv
module wp_data_ram #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    if (re) begin
      rdata <= store[raddr];
    end
  end
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned SET_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [SET_BITS-1:0] req_idx,
  input  logic [1:0]          req_hit,
  input  logic                pred_way,
  output logic                req_ready,
  output logic                upd_en,
  output logic [SET_BITS-1:0] upd_idx,
  output logic                upd_way,
  output logic                rd_en,
  output logic [SET_BITS:0]   rd_addr,
  output logic                rsp_valid,
  output logic                rsp_mispredict,
  output logic                rsp_miss
);
  wp_state_e           state_q;
  logic [SET_BITS-1:0] fix_idx_q;
  logic                fix_way_q;
  logic                accept;
  logic                hit_guess;
  logic                hit_other;

  assign req_ready = (state_q == ST_LOOKUP);
  assign accept    = req_valid && req_ready;
  assign hit_guess = req_hit[pred_way];
  assign hit_other = req_hit[~pred_way];

  always_comb begin
    rd_en   = accept || (state_q == ST_CORRECT);
    rd_addr = (state_q == ST_CORRECT) ? {fix_way_q, fix_idx_q} : {pred_way, req_idx};
    upd_en  = accept && !hit_guess && hit_other;
    upd_idx = req_idx;
    upd_way = ~pred_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_LOOKUP;
      fix_idx_q      <= '0;
      fix_way_q      <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_mispredict <= 1'b0;
      rsp_miss       <= 1'b0;
    end else begin
      case (state_q)
        ST_LOOKUP: begin
          rsp_valid      <= accept && (hit_guess || !hit_other);
          rsp_mispredict <= 1'b0;
          rsp_miss       <= accept && !hit_guess && !hit_other;
          if (upd_en) begin
            state_q   <= ST_CORRECT;
            fix_idx_q <= req_idx;
            fix_way_q <= ~pred_way;
          end
        end
        default: begin
          rsp_valid      <= 1'b1;
          rsp_mispredict <= 1'b1;
          rsp_miss       <= 1'b0;
          state_q        <= ST_LOOKUP;
        end
      endcase
    end
  end

  AST_GUESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && hit_guess) |=> (rsp_valid && !rsp_mispredict && !rsp_miss)); // R2
  AST_OTHER_STALLS: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_guess && hit_other) |=> (!rsp_valid && !req_ready)); // R3
  AST_OTHER_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit_guess && hit_other) |=> ##1 (rsp_valid && rsp_mispredict)); // R3
  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_valid && !rsp_mispredict)); // R5
  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_ready); // R8
endmodule

// File: rtl/way_predictor.sv
module way_predictor #(
  parameter int unsigned SET_BITS = 6,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [SET_BITS-1:0] req_idx,
  input  logic [1:0]          req_hit,
  input  logic                fill_en,
  input  logic                fill_way,
  input  logic [SET_BITS-1:0] fill_idx,
  input  logic [DATA_W-1:0]   fill_data,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                rsp_mispredict,
  output logic                rsp_miss
);
  localparam int unsigned ADDR_W = SET_BITS + $clog2(wp_pkg::NUM_WAYS);

  logic                pred_way;
  logic                upd_en;
  logic [SET_BITS-1:0] upd_idx;
  logic                upd_way;
  logic                rd_en;
  logic [ADDR_W-1:0]   rd_addr;

  wp_pred_table #(.SET_BITS(SET_BITS)) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (req_idx),
    .rd_way  (pred_way),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .upd_way (upd_way)
  );

  wp_ctrl #(.SET_BITS(SET_BITS)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_idx        (req_idx),
    .req_hit        (req_hit),
    .pred_way       (pred_way),
    .req_ready      (req_ready),
    .upd_en         (upd_en),
    .upd_idx        (upd_idx),
    .upd_way        (upd_way),
    .rd_en          (rd_en),
    .rd_addr        (rd_addr),
    .rsp_valid      (rsp_valid),
    .rsp_mispredict (rsp_mispredict),
    .rsp_miss       (rsp_miss)
  );

  wp_data_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (fill_en),
    .waddr ({fill_way, fill_idx}),
    .wdata (fill_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (rsp_data)
  );

  // The prediction table changes only when a lookup lands in the other way.
  AST_UPDATE_NEEDS_OTHER_HIT: assert property (@(posedge clk) disable iff (rst)
    upd_en |-> (req_valid && req_ready && (req_hit != 2'b00) && (req_hit != 2'b11))); // R6
endmodule

// File: tb/tb_way_predictor.sv
module tb_way_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int SET_BITS   = 6;
  localparam int DATA_W     = 32;
  localparam int SETS       = 1 << SET_BITS;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [SET_BITS-1:0] req_idx = '0;
  logic [1:0]          req_hit = '0;
  logic                fill_en = 1'b0;
  logic                fill_way = 1'b0;
  logic [SET_BITS-1:0] fill_idx = '0;
  logic [DATA_W-1:0]   fill_data = '0;
  logic                rsp_valid;
  logic [DATA_W-1:0]   rsp_data;
  logic                rsp_mispredict;
  logic                rsp_miss;

  way_predictor #(.SET_BITS(SET_BITS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_hit(req_hit), .fill_en(fill_en), .fill_way(fill_way),
    .fill_idx(fill_idx), .fill_data(fill_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_mispredict(rsp_mispredict), .rsp_miss(rsp_miss)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [DATA_W-1:0] data;
    bit                mp;
    bit                miss;
    int                cyc;
    string             req;
  } exp_t;

  exp_t              sb[$];
  bit                model_pred [SETS];
  logic [DATA_W-1:0] model_mem  [2][SETS];
  int                checks = 0;
  int                errors = 0;
  int                cyc = 0;
  bit                done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input int idx, input bit h0, input bit h1, input string req);
    exp_t e;
    bit p, hp, ha;
    @(negedge clk);
    while (!req_ready) begin
      req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b1;
    req_idx   = SET_BITS'(idx);
    req_hit   = {h1, h0};
    p  = model_pred[idx];
    hp = p ? h1 : h0;
    ha = p ? h0 : h1;
    e.req = req;
    if (hp) begin
      e.data = model_mem[p][idx]; e.mp = 1'b0; e.miss = 1'b0; e.cyc = cyc + 1;
    end else if (ha) begin
      e.data = model_mem[!p][idx]; e.mp = 1'b1; e.miss = 1'b0; e.cyc = cyc + 2;
      model_pred[idx] = !p;
    end else begin
      e.data = '0; e.mp = 1'b0; e.miss = 1'b1; e.cyc = cyc + 1;
    end
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic fill(input int way, input int idx, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    fill_en   = 1'b1;
    fill_way  = way[0];
    fill_idx  = SET_BITS'(idx);
    fill_data = d;
    model_mem[way][idx] = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // Monitor: pops the scoreboard whenever a response shows up.
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.cyc, e.req, "response cycle", cyc, e.cyc);
        check(rsp_mispredict == e.mp, e.req, "mispredict flag", rsp_mispredict, e.mp);
        check(rsp_miss == e.miss, e.req, "miss flag", rsp_miss, e.miss);
        if (!e.miss) check(rsp_data == e.data, e.req, "data", rsp_data, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0h expected %0h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < SETS; s++) model_pred[s] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

    // R9: load distinct words into every way of every set.
    for (int s = 0; s < SETS; s++) begin
      fill(0, s, 32'hA000_0000 | DATA_W'(s));
      fill(1, s, 32'hB100_0000 | DATA_W'(s * 3));
    end

    // R1: every set starts predicting way 0.
    for (int s = 0; s < SETS; s++) access(s, 1'b1, 1'b0, "R1");
    idle(2);

    // R2: back-to-back correct predictions on several sets.
    access(3, 1'b1, 1'b0, "R2");
    access(40, 1'b1, 1'b0, "R2");
    access(3, 1'b1, 1'b0, "R2");
    idle(2);

    // R3 / R4: mispredict, then corrected guess, then flip back.
    access(5, 1'b0, 1'b1, "R3");
    @(negedge clk);
    check(req_ready == 1'b0, "R3", "req_ready during correction", req_ready, 0);
    access(5, 1'b0, 1'b1, "R4");
    access(5, 1'b1, 1'b0, "R4");
    access(5, 1'b1, 1'b0, "R4");

    // R6: edge sets flip independently of their neighbours.
    access(63, 1'b0, 1'b1, "R6");
    access(62, 1'b1, 1'b0, "R6");
    access(0, 1'b0, 1'b1, "R6");
    access(1, 1'b1, 1'b0, "R6");
    access(63, 1'b0, 1'b1, "R6");
    access(0, 1'b0, 1'b1, "R6");

    // R5: a miss leaves the prediction alone, for either stored way.
    access(63, 1'b0, 1'b0, "R5");
    access(63, 1'b0, 1'b1, "R5");
    access(8, 1'b0, 1'b0, "R5");
    access(8, 1'b1, 1'b0, "R5");

    // R7: both ways hitting returns the predicted way's word.
    access(63, 1'b1, 1'b1, "R7");
    access(8, 1'b1, 1'b1, "R7");

    // R8: a request held during the correction cycle is dropped.
    access(9, 1'b0, 1'b1, "R3");
    @(negedge clk);
    check(req_ready == 1'b0, "R8", "req_ready during stall", req_ready, 0);
    req_valid = 1'b1;
    req_idx   = 10;
    req_hit   = 2'b10;
    idle(3);
    access(10, 1'b1, 1'b0, "R8");
    idle(3);

    // R9: refill a word; prediction unchanged, new word returned.
    fill(1, 5, 32'hC0DE_0005);
    access(5, 1'b1, 1'b0, "R9");
    access(5, 1'b0, 1'b1, "R9");
    fill(0, 20, 32'h1234_5678);
    access(20, 1'b1, 1'b0, "R9");

    // Mixed traffic over many sets.
    for (int i = 0; i < 150; i++) begin
      int idx;
      int sel;
      idx = (i * 37 + 5) % SETS;
      sel = (i * i + i / 3) % 5;
      case (sel)
        0, 3:    access(idx, 1'b1, 1'b0, "R4");
        1, 4:    access(idx, 1'b0, 1'b1, "R4");
        default: access(idx, 1'b0, 1'b0, "R5");
      endcase
    end
    idle(5);
    check(sb.size() == 0, "R3", "responses still pending", sb.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule